// File: doc/BRIEF.md
# Working-Zone Address Bus Codec

This block lowers the switching activity of an external address bus by exploiting the locality of memory references. The transmit side keeps a few zone registers. Each one holds the last address that was sent in its zone. When a new address lies within a few words of a stored zone address, the bus carries the zone number and a one-hot coded signed offset in place of the binary address. Any other address goes out in full, with a miss line raised, and the new address takes over a zone.

The receive side holds its own copy of the zone registers. It updates that copy from the bus alone, so it stays identical to the transmit side and rebuilds every address exactly. Both halves sit in one module. In a system, the bus outputs drive the pads of one chip and the decoder inputs sit behind the pads of the other. For a local loop, the bus outputs can be wired straight back to the decoder inputs.

Top module: `zone_bus_codec`

## Requirements
- R1: After reset every zone is invalid, the bus valid line and the decoded valid line are low, and the bus lines are zero. The first valid address after reset is therefore always sent as a miss on zone 0.
- R2: An address whose signed distance d from a valid zone's stored address satisfies 1 <= |d| <= OFS_POS (7 by default) is sent as a hit. The miss line is low, the zone lines carry that zone's number, bus word bit |d|-1 is set, bit OFS_POS is 1 when d is negative, and every other word bit is zero.
- R3: An address equal to a valid zone's stored address is sent as a hit on that zone with an all-zero bus word.
- R4: When several valid zones are in range, the zone with the lowest number is used.
- R5: An address that is in range of no valid zone is sent with the miss line high and the full address on the bus word. The zone lines name the zone that is replaced: the lowest-numbered invalid zone if there is one, otherwise the least recently used zone.
- R6: A hit replaces the matched zone's stored address with the current address, so the next offset in that zone is measured from it.
- R7: The bus is registered: a valid input in one cycle appears on the bus in the next cycle. In a cycle after the input valid was low, the bus valid is low and the bus word, zone and miss lines keep their previous values.
- R8: The decoder registers its result. One cycle after a valid bus word reaches its inputs it raises its output valid with the exact original address, for both hits and misses.
- R9: While its bus valid input is low, the decoder ignores its other bus inputs. Its output valid stays low, its address output holds, and its zone copy is unchanged.
- R10: A distance of OFS_POS+1 or more in either direction from every valid zone counts as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address to send is valid |
| in_addr | input | ADDR_W | Address to send |
| bus_valid | output | 1 | Encoded bus transfer valid |
| bus_miss | output | 1 | High when the bus word is a full address |
| bus_zone | output | ZONE_W | Zone number of the transfer |
| bus_word | output | ADDR_W | Full address or one-hot offset |
| dec_valid | input | 1 | Received transfer valid |
| dec_miss | input | 1 | Received miss line |
| dec_zone | input | ZONE_W | Received zone number |
| dec_word | input | ADDR_W | Received bus word |
| out_valid | output | 1 | Decoded address valid |
| out_addr | output | ADDR_W | Decoded address |

## Verification
The bench builds the block with its defaults: a 32-bit address, four zones and a seven-position offset field. With four zones, a short directed sequence fills every zone and then forces two replacements by least-recent use. The small field puts both range edges, distance 7 and distance 8, within a few hand-picked addresses. A stream of several hundred mixed local and far addresses then passes through the loop-back and exercises zone reuse, priority between overlapping zones, and replacement in many orders.

// File: rtl/zone_bus_codec.sv
module zone_bus_codec #(
  parameter int ADDR_W  = 32,
  parameter int ZONES   = 4,
  parameter int OFS_POS = 7,
  localparam int ZONE_W = (ZONES > 1) ? $clog2(ZONES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              bus_valid,
  output logic              bus_miss,
  output logic [ZONE_W-1:0] bus_zone,
  output logic [ADDR_W-1:0] bus_word,
  input  logic              dec_valid,
  input  logic              dec_miss,
  input  logic [ZONE_W-1:0] dec_zone,
  input  logic [ADDR_W-1:0] dec_word,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr
);

  localparam logic [ADDR_W-1:0] RANGE = ADDR_W'(OFS_POS);
  localparam logic [ZONE_W-1:0] OLDEST = ZONE_W'(ZONES - 1);

  // transmit-side zone state
  logic [ADDR_W-1:0] tx_base [ZONES];
  logic [ZONES-1:0]  tx_live;
  logic [ZONE_W-1:0] tx_age  [ZONES];

  // receive-side zone copy
  logic [ADDR_W-1:0] rx_base [ZONES];
  logic [ZONES-1:0]  rx_live;

  logic [ADDR_W-1:0] diff [ZONES];
  logic [ADDR_W-1:0] mag  [ZONES];
  logic [ZONES-1:0]  near;

  always_comb begin
    for (int z = 0; z < ZONES; z++) begin
      diff[z] = in_addr - tx_base[z];
      mag[z]  = diff[z][ADDR_W-1] ? (~diff[z] + 1'b1) : diff[z];
      near[z] = tx_live[z] && (mag[z] <= RANGE);
    end
  end

  logic              hit;
  logic [ZONE_W-1:0] hit_id;
  logic [ZONE_W-1:0] new_id;
  logic              have_free;

  always_comb begin
    hit_id = '0;
    for (int z = ZONES - 1; z >= 0; z--)
      if (near[z]) hit_id = ZONE_W'(z);
    have_free = 1'b0;
    new_id    = '0;
    for (int z = ZONES - 1; z >= 0; z--)
      if (!tx_live[z]) begin
        have_free = 1'b1;
        new_id    = ZONE_W'(z);
      end
    if (!have_free)
      for (int z = 0; z < ZONES; z++)
        if (tx_age[z] == OLDEST) new_id = ZONE_W'(z);
  end

  assign hit = |near;

  logic [ZONE_W-1:0] use_id;
  logic [ADDR_W-1:0] use_diff, use_mag;
  logic [ADDR_W-1:0] hit_word;

  assign use_id   = hit ? hit_id : new_id;
  assign use_diff = diff[hit_id];
  assign use_mag  = mag[hit_id];

  always_comb begin
    hit_word = '0;
    for (int b = 0; b < OFS_POS; b++)
      hit_word[b] = (use_mag == ADDR_W'(b + 1));
    hit_word[OFS_POS] = use_diff[ADDR_W-1] && (use_mag != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_valid <= 1'b0;
      bus_miss  <= 1'b0;
      bus_zone  <= '0;
      bus_word  <= '0;
      tx_live   <= '0;
      for (int z = 0; z < ZONES; z++) begin
        tx_base[z] <= '0;
        tx_age[z]  <= ZONE_W'(z);
      end
    end else begin
      bus_valid <= in_valid;
      if (in_valid) begin
        bus_miss <= !hit;
        bus_zone <= use_id;
        bus_word <= hit ? hit_word : in_addr;
        tx_base[use_id] <= in_addr;
        tx_live[use_id] <= 1'b1;
        for (int z = 0; z < ZONES; z++) begin
          if (ZONE_W'(z) == use_id)
            tx_age[z] <= '0;
          else if (tx_age[z] < tx_age[use_id])
            tx_age[z] <= tx_age[z] + 1'b1;
        end
      end
    end
  end

  // receive side
  logic [ADDR_W-1:0] rx_mag;
  logic [ADDR_W-1:0] rx_ref;
  logic [ADDR_W-1:0] rx_addr;

  always_comb begin
    rx_mag = '0;
    for (int b = 0; b < OFS_POS; b++)
      if (dec_word[b]) rx_mag = ADDR_W'(b + 1);
  end

  assign rx_ref  = rx_base[dec_zone];
  assign rx_addr = dec_miss ? dec_word :
                   dec_word[OFS_POS] ? (rx_ref - rx_mag) : (rx_ref + rx_mag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      rx_live   <= '0;
      for (int z = 0; z < ZONES; z++) rx_base[z] <= '0;
    end else begin
      out_valid <= dec_valid;
      if (dec_valid) begin
        out_addr          <= rx_addr;
        rx_base[dec_zone] <= rx_addr;
        rx_live[dec_zone] <= 1'b1;
      end
    end
  end

endmodule

module zone_bus_codec_chk #(
  parameter int ADDR_W  = 32,
  parameter int OFS_POS = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              bus_valid,
  input logic              bus_miss,
  input logic [ADDR_W-1:0] bus_word,
  input logic              dec_valid,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr
);

  logic seen;
  always_ff @(posedge clk)
    if (!rst_n) seen <= 1'b0;
    else if (bus_valid) seen <= 1'b1;

  AST_FIRST_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !seen) |-> bus_miss); // R1

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_miss) |-> ($onehot0(bus_word[OFS_POS-1:0]) &&
      bus_word[ADDR_W-1:OFS_POS+1] == '0)); // R2

  AST_ZERO_NO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_miss && bus_word[OFS_POS-1:0] == '0) |-> !bus_word[OFS_POS]); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!bus_valid && $stable(bus_word))); // R7

  AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> out_valid); // R8

  AST_DEC_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> (!out_valid && $stable(out_addr))); // R9

endmodule

bind zone_bus_codec zone_bus_codec_chk #(.ADDR_W(ADDR_W), .OFS_POS(OFS_POS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bus_valid(bus_valid),
  .bus_miss(bus_miss), .bus_word(bus_word), .dec_valid(dec_valid),
  .out_valid(out_valid), .out_addr(out_addr)
);

// File: tb/zone_bus_codec_tb.sv
module zone_bus_codec_tb;
  localparam int AW = 32;
  localparam int ZW = 2;
  localparam int NS = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic bus_valid, bus_miss, out_valid;
  logic [ZW-1:0] bus_zone;
  logic [AW-1:0] bus_word, out_addr;

  logic loop = 1'b1;
  logic t_dv = 1'b0, t_dm = 1'b0;
  logic [ZW-1:0] t_dz = '0;
  logic [AW-1:0] t_dw = '0;
  logic dv, dm;
  logic [ZW-1:0] dz;
  logic [AW-1:0] dw;

  assign dv = loop ? bus_valid : t_dv;
  assign dm = loop ? bus_miss  : t_dm;
  assign dz = loop ? bus_zone  : t_dz;
  assign dw = loop ? bus_word  : t_dw;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  zone_bus_codec u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .bus_valid(bus_valid), .bus_miss(bus_miss), .bus_zone(bus_zone), .bus_word(bus_word),
    .dec_valid(dv), .dec_miss(dm), .dec_zone(dz), .dec_word(dw),
    .out_valid(out_valid), .out_addr(out_addr)
  );

  task automatic chk(input bit ok, input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one isolated transfer: checks bus, decoder and idle hold
  task automatic send(input logic [AW-1:0] a, input bit miss, input logic [ZW-1:0] zone,
                      input logic [AW-1:0] word, input string req);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(bus_valid == 1'b1, {req, " bus valid"}, AW'(bus_valid), 1);
    chk(bus_miss == miss, {req, " miss line"}, AW'(bus_miss), AW'(miss));
    chk(bus_zone == zone, {req, " zone"}, AW'(bus_zone), AW'(zone));
    chk(bus_word == word, {req, " word"}, bus_word, word);
    @(negedge clk);
    chk(out_valid && out_addr == a, "R8 decoded address", out_addr, a);
    chk(!bus_valid && bus_word == word, "R7 idle hold", bus_word, word);
  endtask

  task automatic t_reset;
    chk(!bus_valid && !out_valid && bus_word == '0 && !bus_miss, "R1 reset state", bus_word, 0);
  endtask

  task automatic t_directed;
    send(32'h1000, 1, 0, 32'h1000, "R1 first access");
    send(32'h1003, 0, 0, 32'h04,   "R2 plus three");
    send(32'h1001, 0, 0, 32'h82,   "R6 minus two from updated base");
    send(32'h1001, 0, 0, 32'h00,   "R3 zero offset");
    send(32'h1009, 1, 1, 32'h1009, "R10 plus eight misses");
    send(32'h1005, 0, 0, 32'h08,   "R4 lowest zone wins");
    send(32'h2000, 1, 2, 32'h2000, "R5 fill zone 2");
    send(32'h3000, 1, 3, 32'h3000, "R5 fill zone 3");
    send(32'h4000, 1, 1, 32'h4000, "R5 replace oldest zone 1");
    send(32'h4001, 0, 1, 32'h01,   "R5 replaced zone reused");
    send(32'h2FF9, 0, 3, 32'hC0,   "R2 minus seven edge");
    send(32'h2FF0, 1, 0, 32'h2FF0, "R10 minus nine misses, R5 oldest zone 0");
    send(32'h2FF7, 0, 0, 32'h40,   "R2 plus seven edge");
  endtask

  task automatic t_dec_ignore;
    @(negedge clk);
    loop = 1'b0;
    t_dv = 1'b0; t_dm = 1'b1; t_dz = 2'd0; t_dw = 32'hDEAD_BEEF;
    @(negedge clk);
    chk(!out_valid && out_addr == 32'h2FF7, "R9 decoder ignores idle bus", out_addr, 32'h2FF7);
    @(negedge clk);
    loop = 1'b1;
    send(32'h2FF8, 0, 0, 32'h01, "R9 zone copy kept");
  endtask

  task automatic t_stream;
    logic [AW-1:0] hist [NS];
    logic [AW-1:0] cur [6];
    for (int k = 0; k < 6; k++) cur[k] = $urandom;
    for (int i = 0; i < NS; i++) begin
      int k;
      k = $urandom_range(5);
      case ($urandom_range(3))
        0: cur[k] = $urandom;
        default: cur[k] = cur[k] + AW'($urandom_range(20)) - AW'(10);
      endcase
      hist[i] = cur[k];
    end
    for (int i = 0; i < NS + 2; i++) begin
      @(negedge clk);
      if (i >= 2)
        chk(out_valid && out_addr == hist[i-2], "R8 stream round trip", out_addr, hist[i-2]);
      in_valid = (i < NS);
      if (i < NS) in_addr = hist[i];
    end
    in_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_directed();
        t_dec_ignore();
        t_stream();
      end
      begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule